// File: doc/BRIEF.md
# Four-Lane Deskew and Alignment Monitor

This block takes four receive lanes of already decoded 8b/10b code groups and lines them up into one channel. Each lane carries a data byte, a control flag and a valid strobe, and the four lanes may arrive with different skews. Every lane writes into its own small deskew FIFO. While the channel is searching, each lane throws away code groups until its FIFO head is the alignment symbol. The lane then holds there until all four heads show it at once. From that column on, the four FIFOs are read together, so the outputs line up column by column.

A monitor classifies each column leaving the FIFOs as full (the alignment symbol on all lanes), partial (on some lanes only) or ordinary. From these it drives a channel-aligned flag with hysteresis. The flag rises on the fourth full column, counting the column that locked the lanes. Once up, it falls after four partial columns in a row. Output valid is only high while the flag is set.

Word alignment, decoding, clock compensation and framing happen elsewhere. Everything runs in one receive clock domain.

Top module: `qdsk_lane_deskew`

## Requirements
- R1: A synchronous active-high reset empties all lane FIFOs, clears the counters and holds `chan_aligned` and `out_valid` low.
- R2: While searching, each lane discards FIFO heads that are not the alignment symbol (control flag 1 with byte 0x7C) and holds at the first one it finds, whatever its skew.
- R3: When all four FIFO heads hold the alignment symbol at once, the lanes lock. From then on one column is read from all lanes together whenever every lane has data. The columns keep their order, with lane i on `out_data[8i+7:8i]` and `out_ctrl[i]`.
- R4: `chan_aligned` rises on the fourth full alignment column after lock, counting the lock column itself. That fourth column is the first one presented.
- R5: `out_valid` is high only while `chan_aligned` is high. Columns read before acquisition, and the column that causes loss, are not presented.
- R6: Once aligned, four partial alignment columns (some lanes with the symbol, others without) with no full column between them drop `chan_aligned`, flush all FIFOs and restart the search.
- R7: A full alignment column seen while aligned restarts the count of partial columns.
- R8: A partial alignment column read after lock but before acquisition flushes all FIFOs and restarts the search.
- R9: A write into a full lane FIFO that is not being read in that cycle flushes all FIFOs, clears the flag and counters, and restarts the search.
- R10: Only control flag 1 with byte 0x7C counts as the alignment symbol. Byte 0x7C with the flag clear, and other control codes, pass through as ordinary data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 4 | Per-lane code-group strobe |
| in_data | input | 32 | Per-lane byte, lane i in bits 8i+7:8i |
| in_ctrl | input | 4 | Per-lane control flag |
| out_valid | output | 1 | Aligned column present |
| out_data | output | 32 | Deskewed column bytes |
| out_ctrl | output | 4 | Deskewed column control flags |
| chan_aligned | output | 1 | Channel alignment status |

## Verification
The assertions assume that, after its own skew, each lane delivers the same column stream at the same rate. They also assume the skew between lanes stays well below the FIFO depth, so a locked channel never overflows. The stimulus builds one column list and feeds it to every lane behind a random prefix of non-alignment garbage of 0 to 6 entries, with every lane strobing on each cycle. Each partial alignment column is followed by ten ordinary columns, so that a search that restarts always lands on the next full column. The overflow case is the one deliberate exception: one lane is driven alone.

// File: rtl/qdsk_pkg.sv
package qdsk_pkg;
    typedef struct packed {
        logic       ctrl;
        logic [7:0] data;
    } sym_t;

    localparam logic [7:0] ALIGN_BYTE = 8'h7C;

    function automatic logic sym_is_align(sym_t s);
        return s.ctrl && (s.data == ALIGN_BYTE);
    endfunction
endpackage

// File: rtl/qdsk_lane_fifo.sv
module qdsk_lane_fifo
    import qdsk_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic push,
    input  sym_t push_sym,
    input  logic pop,
    output sym_t head,
    output logic empty,
    output logic full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    sym_t mem_q [DEPTH];
    logic push_ok, pop_ok;

    assign empty   = (ctl_q.cnt == '0);
    assign full    = (int'(ctl_q.cnt) == DEPTH);
    assign push_ok = push && (!full || pop);
    assign pop_ok  = pop && !empty;
    assign head    = mem_q[ctl_q.rd];

    always_comb begin
        ctl_d = ctl_q;
        if (flush) begin
            ctl_d = '0;
        end else begin
            if (push_ok)
                ctl_d.wr = (int'(ctl_q.wr) == DEPTH - 1) ? '0 : ctl_q.wr + 1'b1;
            if (pop_ok)
                ctl_d.rd = (int'(ctl_q.rd) == DEPTH - 1) ? '0 : ctl_q.rd + 1'b1;
            if (push_ok && !pop_ok)
                ctl_d.cnt = ctl_q.cnt + 1'b1;
            else if (pop_ok && !push_ok)
                ctl_d.cnt = ctl_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok && !flush)
            mem_q[ctl_q.wr] <= push_sym;
    end

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty);  // R8
    AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);  // R3
endmodule

// File: rtl/qdsk_align_mon.sv
module qdsk_align_mon #(
    parameter int ACQ_COLS  = 4,
    parameter int LOSS_COLS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic col_pop,
    input  logic col_full,
    input  logic col_part,
    output logic aligned_d,
    output logic aligned_q,
    output logic restart
);
    localparam int AW = $clog2(ACQ_COLS + 1);
    localparam int LW = $clog2(LOSS_COLS + 1);

    typedef struct packed {
        logic          aligned;
        logic [AW-1:0] acq;
        logic [LW-1:0] mis;
    } mon_t;

    mon_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        restart = 1'b0;
        if (clear) begin
            st_d = '0;
        end else if (col_pop) begin
            if (!st_q.aligned) begin
                if (col_full) begin
                    if (int'(st_q.acq) == ACQ_COLS - 1) begin
                        st_d.aligned = 1'b1;
                        st_d.acq     = '0;
                        st_d.mis     = '0;
                    end else begin
                        st_d.acq = st_q.acq + 1'b1;
                    end
                end else if (col_part) begin
                    restart  = 1'b1;
                    st_d.acq = '0;
                end
            end else begin
                if (col_full) begin
                    st_d.mis = '0;
                end else if (col_part) begin
                    if (int'(st_q.mis) == LOSS_COLS - 1) begin
                        st_d.aligned = 1'b0;
                        st_d.mis     = '0;
                        restart      = 1'b1;
                    end else begin
                        st_d.mis = st_q.mis + 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign aligned_d = st_d.aligned;
    assign aligned_q = st_q.aligned;

    AST_RISE_ON_FULL_COL: assert property (@(posedge clk) disable iff (rst)
        $rose(aligned_q) |-> $past(col_pop && col_full));  // R4
    AST_FALL_ON_MISALIGN: assert property (@(posedge clk) disable iff (rst)
        $fell(aligned_q) |-> $past(clear || (col_pop && col_part)));  // R6
    AST_FULL_KEEPS_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (aligned_q && col_pop && col_full && !clear) |=> aligned_q);  // R7
endmodule

// File: rtl/qdsk_lane_deskew.sv
module qdsk_lane_deskew
    import qdsk_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int FIFO_DEPTH = 16,
    parameter int ACQ_COLS   = 4,
    parameter int LOSS_COLS  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [LANES-1:0]   in_valid,
    input  logic [8*LANES-1:0] in_data,
    input  logic [LANES-1:0]   in_ctrl,
    output logic               out_valid,
    output logic [8*LANES-1:0] out_data,
    output logic [LANES-1:0]   out_ctrl,
    output logic               chan_aligned
);
    localparam int DW = 8 * LANES;

    typedef struct packed {
        logic             locked;
        logic             ovalid;
        logic [DW-1:0]    odata;
        logic [LANES-1:0] octrl;
    } top_t;

    top_t st_d, st_q;

    sym_t             head   [LANES];
    logic [LANES-1:0] empty, full, head_a, lane_pop, lane_ovf;
    logic             col_pop, col_full, col_part, overflow, flush;
    logic             mon_aligned_d, mon_aligned_q, mon_restart;

    assign col_full = &head_a;
    assign col_part = (|head_a) && !col_full;
    assign col_pop  = (&(~empty)) && (st_q.locked || col_full);
    assign overflow = |lane_ovf;
    assign flush    = overflow || mon_restart;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        sym_t in_sym;
        assign in_sym      = '{ctrl: in_ctrl[i], data: in_data[8*i +: 8]};
        assign head_a[i]   = !empty[i] && sym_is_align(head[i]);
        assign lane_pop[i] = col_pop || (!st_q.locked && !empty[i] && !head_a[i]);
        assign lane_ovf[i] = in_valid[i] && full[i] && !lane_pop[i];

        qdsk_lane_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
            .clk      (clk),
            .rst      (rst),
            .flush    (flush),
            .push     (in_valid[i]),
            .push_sym (in_sym),
            .pop      (lane_pop[i]),
            .head     (head[i]),
            .empty    (empty[i]),
            .full     (full[i])
        );
    end

    qdsk_align_mon #(.ACQ_COLS(ACQ_COLS), .LOSS_COLS(LOSS_COLS)) u_mon (
        .clk       (clk),
        .rst       (rst),
        .clear     (overflow),
        .col_pop   (col_pop),
        .col_full  (col_full),
        .col_part  (col_part),
        .aligned_d (mon_aligned_d),
        .aligned_q (mon_aligned_q),
        .restart   (mon_restart)
    );

    always_comb begin
        st_d        = st_q;
        st_d.ovalid = col_pop && mon_aligned_d;
        if (flush)        st_d.locked = 1'b0;
        else if (col_pop) st_d.locked = 1'b1;
        if (col_pop) begin
            for (int i = 0; i < LANES; i++) begin
                st_d.odata[8*i +: 8] = head[i].data;
                st_d.octrl[i]        = head[i].ctrl;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid    = st_q.ovalid;
    assign out_data     = st_q.odata;
    assign out_ctrl     = st_q.octrl;
    assign chan_aligned = mon_aligned_q;

    AST_VALID_NEEDS_ALIGN: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> chan_aligned);  // R5
    AST_LOCK_ON_FULL_COL: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.locked) |-> $past(col_full));  // R3
    AST_OVF_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        overflow |=> (!chan_aligned && !st_q.locked));  // R9
    AST_NO_COLUMN_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (|empty) |=> !out_valid);  // R5
endmodule

// File: tb/qdsk_lane_deskew_test.sv
module qdsk_lane_deskew_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  in_valid = '0;
    logic [31:0] in_data  = '0;
    logic [3:0]  in_ctrl  = '0;
    logic        out_valid;
    logic [31:0] out_data;
    logic [3:0]  out_ctrl;
    logic        chan_aligned;

    always #2 clk = ~clk;

    qdsk_lane_deskew uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ctrl(in_ctrl), .out_valid(out_valid), .out_data(out_data),
        .out_ctrl(out_ctrl), .chan_aligned(chan_aligned)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;
    string cur_tag = "";
    logic model_aligned;

    logic [8:0]  lane_q [4][$];
    logic [35:0] cols[$];
    logic [35:0] exp_q[$];

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [35:0] mk_full();
        return {4'hF, 32'h7C7C7C7C};
    endfunction

    function automatic logic [8:0] mk_sym();
        logic [7:0] b = 8'($urandom);
        logic       c = 1'($urandom);
        if ($urandom % 6 == 0) begin b = 8'h7C; c = 1'b0; end  // R10 look-alike
        if (c && b == 8'h7C) b = 8'hBC;
        return {c, b};
    endfunction

    function automatic logic [35:0] mk_data();
        logic [35:0] r;
        for (int i = 0; i < 4; i++) begin
            logic [8:0] s = mk_sym();
            r[32+i]     = s[8];
            r[8*i +: 8] = s[7:0];
        end
        return r;
    endfunction

    function automatic logic [35:0] mk_part(input logic [3:0] mask);
        logic [35:0] r = mk_data();
        for (int i = 0; i < 4; i++)
            if (mask[i]) begin r[32+i] = 1'b1; r[8*i +: 8] = 8'h7C; end
        return r;
    endfunction

    task automatic add_data(input int n);
        for (int k = 0; k < n; k++) cols.push_back(mk_data());
    endtask

    task automatic add_part();
        logic [3:0] m = 4'(1 + $urandom % 14);
        cols.push_back(mk_part(m));
        add_data(10);
    endtask

    function automatic int count_a(input logic [35:0] c);
        int n = 0;
        for (int i = 0; i < 4; i++)
            if (c[32+i] && c[8*i +: 8] == 8'h7C) n++;
        return n;
    endfunction

    task automatic build_expect();
        int st = 0;
        int acq = 0;
        int mis = 0;
        exp_q.delete();
        foreach (cols[k]) begin
            int na = count_a(cols[k]);
            case (st)
                0: if (na == 4) begin st = 1; acq = 1; end
                1: begin
                    if (na == 4) begin
                        acq++;
                        if (acq == 4) begin st = 2; mis = 0; exp_q.push_back(cols[k]); end
                    end else if (na > 0) st = 0;
                end
                default: begin
                    if (na == 4) begin mis = 0; exp_q.push_back(cols[k]); end
                    else if (na > 0) begin
                        mis++;
                        if (mis == 4) st = 0; else exp_q.push_back(cols[k]);
                    end else exp_q.push_back(cols[k]);
                end
            endcase
        end
        model_aligned = (st == 2);
    endtask

    task automatic load_lanes(input int s0, input int s1, input int s2, input int s3);
        int sk[4] = '{s0, s1, s2, s3};
        for (int i = 0; i < 4; i++) begin
            for (int k = 0; k < sk[i]; k++) lane_q[i].push_back(mk_sym());
            foreach (cols[k]) lane_q[i].push_back({cols[k][32+i], cols[k][8*i +: 8]});
        end
    endtask

    task automatic sample();
        if (out_valid) begin
            chk(chan_aligned, "R5", "out_valid while not aligned", 36'(chan_aligned), 36'd1);
            if (exp_q.size() == 0)
                chk(1'b0, cur_tag, "unexpected column", {out_ctrl, out_data}, 36'd0);
            else begin
                logic [35:0] e = exp_q.pop_front();
                chk({out_ctrl, out_data} == e, cur_tag, "column", {out_ctrl, out_data}, e);
            end
        end
    endtask

    task automatic run_lanes();
        while (lane_q[0].size() + lane_q[1].size() + lane_q[2].size() + lane_q[3].size() > 0) begin
            @(negedge clk);
            sample();
            for (int i = 0; i < 4; i++) begin
                if (lane_q[i].size() > 0) begin
                    logic [8:0] s = lane_q[i].pop_front();
                    in_valid[i] = 1'b1; in_ctrl[i] = s[8]; in_data[8*i +: 8] = s[7:0];
                end else in_valid[i] = 1'b0;
            end
        end
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            sample();
            in_valid = '0;
        end
    endtask

    task automatic finish_scn();
        chk(exp_q.size() == 0, cur_tag, "columns left unpresented", 36'(exp_q.size()), 36'd0);
        chk(chan_aligned == model_aligned, cur_tag, "final chan_aligned",
            36'(chan_aligned), 36'(model_aligned));
    endtask

    task automatic do_reset();
        for (int i = 0; i < 4; i++) lane_q[i].delete();
        cols.delete();
        exp_q.delete();
        @(negedge clk);
        rst = 1'b1; in_valid = '0;
        repeat (3) @(negedge clk);
        chk(!chan_aligned, "R1", "chan_aligned in reset", 36'(chan_aligned), 36'd0);
        chk(!out_valid, "R1", "out_valid in reset", 36'(out_valid), 36'd0);
        rst = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));

        // Scenario 1: skewed lanes, acquisition, look-alike data (R2 R3 R4 R10)
        do_reset();
        cur_tag = "R2 R3 R4 R10";
        cols.push_back(mk_full());
        for (int b = 0; b < 12; b++) begin
            add_data(1 + $urandom % 5);
            cols.push_back(mk_full());
        end
        add_data(6);
        build_expect();
        load_lanes(0, 6, 3, 1);
        run_lanes();
        finish_scn();

        // Random-skew repeats of scenario 1 (R2 R3 R4)
        for (int r = 0; r < 3; r++) begin
            do_reset();
            cur_tag = "R2 R3 R4";
            cols.push_back(mk_full());
            for (int b = 0; b < 8; b++) begin
                add_data($urandom % 4);
                cols.push_back(mk_full());
            end
            add_data(20);
            build_expect();
            load_lanes($urandom % 7, $urandom % 7, $urandom % 7, $urandom % 7);
            run_lanes();
            finish_scn();
        end

        // Scenario 2: run broken by a full column, then loss and reacquire (R6 R7)
        do_reset();
        cur_tag = "R6 R7";
        cols.push_back(mk_full()); add_data(2);
        cols.push_back(mk_full()); add_data(1);
        cols.push_back(mk_full()); cols.push_back(mk_full()); add_data(3);
        add_part(); add_part(); add_part();
        cols.push_back(mk_full()); add_data(2);
        add_part(); add_part(); add_part();
        add_part();
        cols.push_back(mk_full()); add_data(1);
        cols.push_back(mk_full()); cols.push_back(mk_full()); add_data(2);
        cols.push_back(mk_full()); add_data(5);
        build_expect();
        load_lanes($urandom % 7, $urandom % 7, $urandom % 7, $urandom % 7);
        run_lanes();
        finish_scn();

        // Scenario 3: partial column before acquisition restarts (R8)
        do_reset();
        cur_tag = "R8";
        cols.push_back(mk_full()); add_data(1);
        cols.push_back(mk_full()); add_data(1);
        add_part();
        cols.push_back(mk_full()); add_data(2);
        cols.push_back(mk_full()); cols.push_back(mk_full());
        cols.push_back(mk_full()); add_data(5);
        build_expect();
        load_lanes($urandom % 7, $urandom % 7, $urandom % 7, $urandom % 7);
        run_lanes();
        finish_scn();

        // Scenario 4: overflow on one lane flushes stale content (R9)
        do_reset();
        cur_tag = "R9";
        lane_q[0].push_back(9'h17C);
        for (int k = 0; k < 16; k++) lane_q[0].push_back({1'b0, 8'(k + 1)});
        run_lanes();
        chk(!chan_aligned, "R9", "aligned after overflow", 36'(chan_aligned), 36'd0);
        cols.push_back(mk_full()); add_data(1);
        cols.push_back(mk_full()); cols.push_back(mk_full());
        cols.push_back(mk_full()); add_data(6);
        build_expect();
        load_lanes(2, 0, 5, 1);
        run_lanes();
        finish_scn();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule